// File: doc/BRIEF.md
# Serial Word EEPROM Slave Model

This block is a synthesizable model of a small serial EEPROM that stores 16-bit words. It is meant to sit on the far side of a serial master inside a self-checking environment. The master frames each command with an active-high select and clocks bits in mode 0: data is sampled on the rising serial clock and changed on the falling one. Every command begins with a start bit of 1, followed by a two-bit operation code and an eight-bit address.

A read returns one word, most significant bit first, after a single dummy zero. A write takes one word and stores it. Two extended codes share operation code 00 and are told apart by the top two address bits: one arms a write-enable latch, the other fills the whole array with ones. Stores and fills only take effect while that latch is armed. The array is treated as non-volatile, so reset clears the latch and the frame logic but leaves stored words untouched.

The serial pins are oversampled by the system clock through a synchronizer. The serial clock must therefore stay in each phase for several system cycles.

Top module: `ser_eeprom_slave`

## Requirements
- R1: Reset clears the write-enable latch and deasserts `ser_out_en`. Stored words keep their values across reset.
- R2: While select is high, zeros sampled before the first 1 are ignored. That first 1 is the start bit. The next 10 rising-edge samples are the operation code (2 bits), then the address (8 bits), each field MSB first.
- R3: Operation code 10 reads. After the last address bit, `ser_out_en` rises and `ser_out` presents 0, so the master's next rising-edge sample is a dummy 0. Each following falling edge presents the next bit of the addressed word, MSB first. After the 16 bits, `ser_out` stays 0.
- R4: Operation code 01 writes. When the latch is armed, the 16 bits sampled after the header are stored MSB first at the addressed word once the 16th bit is sampled.
- R5: A write received while the latch is clear leaves the array unchanged.
- R6: Operation code 00 with address bits [7:6] = 11 arms the latch. Only reset clears it.
- R7: Operation code 00 with address bits [7:6] = 10 sets every word to 0xFFFF when the latch is armed. Otherwise it changes nothing.
- R8: The array holds 128 words indexed by address bits [6:0]. Address bit 7 does not select a word, so addresses A and A^0x80 name the same word.
- R9: `ser_out_en` is low during the header and during write frames. It falls within SYNC_STAGES+1 clock cycles of select going low.
- R10: Serial clocks after a command has completed are ignored until select falls. Operation code 11, and code 00 with address bits [7:6] equal to 00 or 01, change nothing.
- R11: A frame whose select falls before all 16 write bits arrive stores nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel | input | 1 | Active-high frame select |
| ser_clk | input | 1 | Serial clock driven by the master (idles low) |
| ser_in | input | 1 | Serial data from the master |
| ser_out | output | 1 | Serial data to the master |
| ser_out_en | output | 1 | Output drive enable; low stands for a high-impedance pin |

## Verification
The checker watches several properties on every clock. The output enable must drop once select has been low long enough. The output bit may change only after a detected falling serial edge. Neither a store nor a fill may occur while the latch is clear, and once armed the latch may not fall. What the assertions cannot see is whether the right word landed at the right index. That covers header decoding with leading zeros, address aliasing, the dummy bit, extra clocks after a command and aborted writes. Only the bench's frames show these, by reading words back against a reference array it keeps from the requirements.

// File: rtl/ser_ee_pkg.sv
package ser_ee_pkg;

   // operation code carried right after the start bit
   typedef enum logic [1:0] {
      OP_EXT   = 2'b00,
      OP_WRITE = 2'b01,
      OP_READ  = 2'b10,
      OP_CLEAR = 2'b11
   } ee_op_e;

   // sub-codes held in the two top address bits of an extended command
   localparam logic [1:0] SUB_ARM  = 2'b11;
   localparam logic [1:0] SUB_FILL = 2'b10;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_HDR,
      ST_WDAT,
      ST_RLOAD,
      ST_RDAT,
      ST_DONE
   } ee_state_e;

endpackage

// File: rtl/ser_ee_sync.sv
module ser_ee_sync #(
   parameter int STAGES = 2,
   parameter int WIDTH  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
         end
      end else begin : g_many
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ser_ee_store.sv
module ser_ee_store #(
   parameter int DATA_W      = 16,
   parameter int DEPTH       = 128,
   parameter int IDX_W       = 7,
   parameter int ERASE_STYLE = 0
) (
   input  logic              clk,
   input  logic              store_en,
   input  logic [IDX_W-1:0]  store_idx,
   input  logic [DATA_W-1:0] store_word,
   input  logic              wipe_en,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_word
);

   logic [DATA_W-1:0] mem [DEPTH];

   generate
      if (ERASE_STYLE == 0) begin : g_flat
         // every word is overwritten in the fill cycle
         always_ff @(posedge clk) begin
            if (wipe_en) begin
               for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
            end else if (store_en) begin
               mem[store_idx] <= store_word;
            end
         end
         assign rd_word = mem[rd_idx];
      end else begin : g_mask
         // one live bit per word; a dead word reads as all ones
         logic [DEPTH-1:0] live;
         always_ff @(posedge clk) begin
            if (wipe_en)       live <= '0;
            else if (store_en) live[store_idx] <= 1'b1;
         end
         always_ff @(posedge clk) begin
            if (store_en) mem[store_idx] <= store_word;
         end
         assign rd_word = live[rd_idx] ? mem[rd_idx] : '1;
      end
   endgenerate

endmodule

// File: rtl/ser_ee_frame.sv
module ser_ee_frame
   import ser_ee_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 8,
   parameter int IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_s,
   input  logic              sck_rise,
   input  logic              sck_fall,
   input  logic              din_s,
   input  logic [DATA_W-1:0] rd_word,
   output logic [IDX_W-1:0]  word_idx,
   output logic              store_en,
   output logic [DATA_W-1:0] store_word,
   output logic              wipe_en,
   output logic              wen_q,
   output logic              dout,
   output logic              dout_oe
);

   localparam int HDR_W   = 2 + ADDR_W;
   localparam int CNT_MAX = (HDR_W > DATA_W) ? HDR_W : DATA_W;
   localparam int CNT_W   = $clog2(CNT_MAX + 1);

   ee_state_e         st;
   logic [CNT_W-1:0]  cnt;
   logic [HDR_W-2:0]  hdr_sh;
   logic [DATA_W-2:0] wr_sh;
   logic [DATA_W:0]   rd_sh;

   logic [HDR_W-1:0]  hdr_next;
   logic [DATA_W-1:0] wr_next;
   ee_op_e            op_dec;
   logic [1:0]        sub_dec;
   logic              hdr_last;
   logic              wr_last;

   always_comb begin
      hdr_next = {hdr_sh, din_s};
      wr_next  = {wr_sh, din_s};
      op_dec   = ee_op_e'(hdr_next[HDR_W-1 -: 2]);
      sub_dec  = hdr_next[ADDR_W-1 -: 2];
      hdr_last = (cnt == CNT_W'(HDR_W - 1));
      wr_last  = (cnt == CNT_W'(DATA_W - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st         <= ST_IDLE;
         cnt        <= '0;
         hdr_sh     <= '0;
         wr_sh      <= '0;
         rd_sh      <= '0;
         word_idx   <= '0;
         store_en   <= 1'b0;
         store_word <= '0;
         wipe_en    <= 1'b0;
         wen_q      <= 1'b0;
         dout       <= 1'b0;
         dout_oe    <= 1'b0;
      end else begin
         store_en <= 1'b0;
         wipe_en  <= 1'b0;
         if (!cs_s) begin
            st      <= ST_IDLE;
            cnt     <= '0;
            dout    <= 1'b0;
            dout_oe <= 1'b0;
         end else begin
            case (st)
               ST_IDLE: begin
                  if (sck_rise && din_s) begin
                     st  <= ST_HDR;
                     cnt <= '0;
                  end
               end
               ST_HDR: begin
                  if (sck_rise) begin
                     hdr_sh <= hdr_next[HDR_W-2:0];
                     cnt    <= cnt + 1'b1;
                     if (hdr_last) begin
                        cnt      <= '0;
                        word_idx <= hdr_next[IDX_W-1:0];
                        case (op_dec)
                           OP_READ: begin
                              st      <= ST_RLOAD;
                              dout    <= 1'b0;
                              dout_oe <= 1'b1;
                           end
                           OP_WRITE: st <= ST_WDAT;
                           OP_EXT: begin
                              st <= ST_DONE;
                              if (sub_dec == SUB_ARM)       wen_q   <= 1'b1;
                              else if (sub_dec == SUB_FILL) wipe_en <= wen_q;
                           end
                           default: st <= ST_DONE;
                        endcase
                     end
                  end
               end
               ST_WDAT: begin
                  if (sck_rise) begin
                     wr_sh <= wr_next[DATA_W-2:0];
                     cnt   <= cnt + 1'b1;
                     if (wr_last) begin
                        store_en   <= wen_q;
                        store_word <= wr_next;
                        st         <= ST_DONE;
                     end
                  end
               end
               ST_RLOAD: begin
                  // leading zero becomes the dummy bit on the next falling edge
                  rd_sh <= {1'b0, rd_word};
                  st    <= ST_RDAT;
               end
               ST_RDAT: begin
                  if (sck_fall) begin
                     dout  <= rd_sh[DATA_W];
                     rd_sh <= {rd_sh[DATA_W-1:0], 1'b0};
                  end
               end
               default: ;
            endcase
         end
      end
   end

endmodule

// File: rtl/ser_eeprom_slave.sv
module ser_eeprom_slave #(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 8,
   parameter int DEPTH       = 128,
   parameter int SYNC_STAGES = 2,
   parameter int ERASE_STYLE = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic chip_sel,
   input  logic ser_clk,
   input  logic ser_in,
   output logic ser_out,
   output logic ser_out_en
);

   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("DEPTH must be a power of two of at least 2");
      end
      if (DEPTH > (1 << ADDR_W)) begin : g_bad_span
         $error("DEPTH exceeds the address field");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("ADDR_W must hold the two extended sub-code bits");
      end
      if (DATA_W < 2) begin : g_bad_data
         $error("DATA_W must be at least 2");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 1");
      end
      if (ERASE_STYLE < 0 || ERASE_STYLE > 1) begin : g_bad_style
         $error("ERASE_STYLE must be 0 or 1");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              cs_s;
   logic              sck_s;
   logic              din_s;
   logic              sck_prev;
   logic              sck_rise;
   logic              sck_fall;
   logic [IDX_W-1:0]  word_idx;
   logic              store_en;
   logic [DATA_W-1:0] store_word;
   logic              wipe_en;
   logic              wen_q;
   logic [DATA_W-1:0] rd_word;

   ser_ee_sync #(
      .STAGES (SYNC_STAGES),
      .WIDTH  (3)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({chip_sel, ser_clk, ser_in}),
      .q     (pins_s)
   );

   assign cs_s  = pins_s[2];
   assign sck_s = pins_s[1];
   assign din_s = pins_s[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_prev <= 1'b0;
      else        sck_prev <= sck_s;
   end

   assign sck_rise = sck_s & ~sck_prev;
   assign sck_fall = ~sck_s & sck_prev;

   ser_ee_frame #(
      .DATA_W (DATA_W),
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .cs_s       (cs_s),
      .sck_rise   (sck_rise),
      .sck_fall   (sck_fall),
      .din_s      (din_s),
      .rd_word    (rd_word),
      .word_idx   (word_idx),
      .store_en   (store_en),
      .store_word (store_word),
      .wipe_en    (wipe_en),
      .wen_q      (wen_q),
      .dout       (ser_out),
      .dout_oe    (ser_out_en)
   );

   ser_ee_store #(
      .DATA_W      (DATA_W),
      .DEPTH       (DEPTH),
      .IDX_W       (IDX_W),
      .ERASE_STYLE (ERASE_STYLE)
   ) u_store (
      .clk        (clk),
      .store_en   (store_en),
      .store_idx  (word_idx),
      .store_word (store_word),
      .wipe_en    (wipe_en),
      .rd_idx     (word_idx),
      .rd_word    (rd_word)
   );

endmodule

// File: rtl/ser_ee_checks.sv
module ser_ee_checks #(
   parameter int SYNC_STAGES = 2
) (
   input logic clk,
   input logic rst_n,
   input logic chip_sel,
   input logic ser_out,
   input logic ser_out_en,
   input logic sck_fall,
   input logic wen_q,
   input logic store_en,
   input logic wipe_en
);

   localparam int LIM = SYNC_STAGES + 1;
   localparam int CW  = $clog2(LIM + 2);

   logic [CW-1:0] low_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  low_cnt <= '0;
      else if (chip_sel)           low_cnt <= '0;
      else if (low_cnt != CW'(LIM)) low_cnt <= low_cnt + 1'b1;
   end

   AST_DESELECT_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (low_cnt == CW'(LIM)) |-> !ser_out_en);   // R9

   AST_BIT_HOLDS_BETWEEN_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_out_en && $past(ser_out_en) && !$past(sck_fall)) |-> $stable(ser_out));   // R3

   AST_ARM_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $past(wen_q) |-> wen_q);   // R6

   AST_STORE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      store_en |-> wen_q);   // R5

   AST_FILL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      wipe_en |-> wen_q);   // R7

   AST_ONE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
      !(store_en && wipe_en));   // R4

endmodule

bind ser_eeprom_slave ser_ee_checks #(.SYNC_STAGES(SYNC_STAGES)) u_checks (
   .clk        (clk),
   .rst_n      (rst_n),
   .chip_sel   (chip_sel),
   .ser_out    (ser_out),
   .ser_out_en (ser_out_en),
   .sck_fall   (sck_fall),
   .wen_q      (wen_q),
   .store_en   (store_en),
   .wipe_en    (wipe_en)
);

// File: tb/tb_ser_eeprom_slave.sv
`timescale 1ns/1ps
module tb_ser_eeprom_slave;

   localparam int HP = 8;   // system cycles per serial clock phase
   localparam int WD = 190000;
   localparam logic [1:0] C_EXT = 2'b00, C_WR = 2'b01, C_RD = 2'b10, C_CLR = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic chip_sel = 1'b0;
   logic ser_clk = 1'b0;
   logic ser_in = 1'b0;
   logic ser_out;
   logic ser_out_en;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;
   logic ref_arm = 1'b0;
   logic [15:0] ref_mem [128];

   always #4 clk = ~clk;

   ser_eeprom_slave dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .chip_sel   (chip_sel),
      .ser_clk    (ser_clk),
      .ser_in     (ser_in),
      .ser_out    (ser_out),
      .ser_out_en (ser_out_en)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic clk_bit(input logic b, output logic smp, output logic oe);
      ser_in = b;
      repeat (HP) @(negedge clk);
      smp = ser_out;
      oe  = ser_out_en;
      ser_clk = 1'b1;
      repeat (HP) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic run_frame(input int lead0, input logic [1:0] op, input logic [7:0] adr,
                            input int n_tail, input logic [31:0] tail,
                            output logic [31:0] got, output logic hdr_oe, output logic tail_oe);
      logic s, o;
      got = '0; hdr_oe = 1'b0; tail_oe = 1'b0;
      chip_sel = 1'b1;
      repeat (HP) @(negedge clk);
      for (int i = 0; i < lead0; i++) begin clk_bit(1'b0, s, o); hdr_oe |= o; end
      clk_bit(1'b1, s, o); hdr_oe |= o;
      for (int i = 1; i >= 0; i--) begin clk_bit(op[i], s, o); hdr_oe |= o; end
      for (int i = 7; i >= 0; i--) begin clk_bit(adr[i], s, o); hdr_oe |= o; end
      for (int i = n_tail - 1; i >= 0; i--) begin
         clk_bit(tail[i], s, o);
         got = {got[30:0], s};
         tail_oe |= o;
      end
      ser_in = 1'b0;
      repeat (HP) @(negedge clk);
      chip_sel = 1'b0;
      repeat (2 * HP) @(negedge clk);
   endtask

   task automatic read_check(input string tag, input logic [7:0] adr);
      logic [31:0] got;
      logic ho, to;
      run_frame(0, C_RD, adr, 17, 32'h0, got, ho, to);
      chk({tag, " R3 dummy"}, {31'h0, got[16]}, 32'h0);
      chk({tag, " data"}, {16'h0, got[15:0]}, {16'h0, ref_mem[adr[6:0]]});
      chk("R9 oe low in read header", {31'h0, ho}, 32'h0);
      chk("R9 oe low after deselect", {31'h0, ser_out_en}, 32'h0);
   endtask

   task automatic write_cmd(input int lead0, input logic [7:0] adr, input logic [15:0] data, input int extra);
      logic [31:0] got, tail;
      logic ho, to;
      tail = ({16'h0, data} << extra) | ((32'h1 << extra) - 32'h1);
      run_frame(lead0, C_WR, adr, 16 + extra, tail, got, ho, to);
      if (ref_arm) ref_mem[adr[6:0]] = data;
      chk("R9 oe low in write frame", {30'h0, ho, to}, 32'h0);
   endtask

   task automatic ext_cmd(input logic [1:0] op, input logic [7:0] adr, input int n_tail);
      logic [31:0] got;
      logic ho, to;
      run_frame(0, op, adr, n_tail, 32'hFFFF_FFFF, got, ho, to);
      if (op == C_EXT && adr[7:6] == 2'b11) ref_arm = 1'b1;
      if (op == C_EXT && adr[7:6] == 2'b10 && ref_arm)
         for (int i = 0; i < 128; i++) ref_mem[i] = 16'hFFFF;
   endtask

   task automatic pulse_reset();
      rst_n = 1'b0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      ref_arm = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   initial begin
      logic [31:0] got;
      logic ho, to;
      logic [7:0] a;
      logic [15:0] d;
      int pick;
      void'($urandom(32'h0005_EED5));
      for (int i = 0; i < 128; i++) ref_mem[i] = 16'hFFFF;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk("R1 oe low after reset", {31'h0, ser_out_en}, 32'h0);

      // arm and fill so the array has known contents
      ext_cmd(C_EXT, 8'hC0, 0);
      ext_cmd(C_EXT, 8'h80, 0);
      read_check("R7 fill reads ones", 8'h05);

      // directed writes and reads
      write_cmd(0, 8'h03, 16'h0003, 0);
      read_check("R4 word at 3", 8'h03);
      write_cmd(0, 8'h7F, 16'h8001, 0);
      read_check("R4 top word", 8'h7F);
      write_cmd(3, 8'h21, 16'hBEEF, 0);
      read_check("R2 leading zeros", 8'h21);
      write_cmd(0, 8'h85, 16'hA5A5, 0);
      read_check("R8 alias read", 8'h05);
      read_check("R8 alias read high", 8'h85);

      // extra clocks, reserved codes, other extended sub-codes
      write_cmd(0, 8'h0A, 16'h1234, 8);
      read_check("R10 extra clocks", 8'h0A);
      ext_cmd(C_CLR, 8'h0A, 16);
      read_check("R10 code 11 no effect", 8'h0A);
      ext_cmd(C_EXT, 8'h4A, 16);
      read_check("R10 sub 01 no effect", 8'h0A);
      ext_cmd(C_EXT, 8'h0A, 16);
      read_check("R10 sub 00 no effect", 8'h0A);

      // write aborted by deselect
      run_frame(0, C_WR, 8'h0A, 8, 32'h0000_0055, got, ho, to);
      read_check("R11 abort keeps word", 8'h0A);

      // random mix
      for (int k = 0; k < 45; k++) begin
         pick = $urandom_range(0, 99);
         a = 8'($urandom_range(0, 255));
         d = 16'($urandom);
         if (pick < 45)      write_cmd(0, a, d, 0);
         else if (pick < 90) read_check("R4 random readback", a);
         else if (pick < 97) begin
            write_cmd(int'($urandom_range(1, 4)), a, d, 0);
            read_check("R2 random leading zeros", a);
         end else begin
            ext_cmd(C_EXT, 8'h80, 0);
            read_check("R7 random fill", a);
         end
      end

      // reset keeps contents but disarms
      write_cmd(0, 8'h44, 16'h5A5A, 0);
      pulse_reset();
      chk("R1 oe low after second reset", {31'h0, ser_out_en}, 32'h0);
      read_check("R1 word kept over reset", 8'h44);
      write_cmd(0, 8'h44, 16'h0F0F, 0);
      read_check("R5 write ignored while disarmed", 8'h44);
      ext_cmd(C_EXT, 8'h80, 0);
      read_check("R7 fill ignored while disarmed", 8'h44);
      ext_cmd(C_EXT, 8'hFF, 0);
      write_cmd(0, 8'h44, 16'h0F0F, 0);
      read_check("R6 write after re-arm", 8'h44);
      write_cmd(0, 8'h45, 16'hC3C3, 0);
      read_check("R6 arm persists across frames", 8'h45);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (WD) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog expired act=running exp=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

endmodule